// File: doc/BRIEF.md
# Floating-Point Condition Code Unit

This block keeps the four-bit condition code of a floating-point datapath and answers branch predicates against it. When a result strobe arrives, the single-precision result word is classified by sign and data type (finite, zero, infinity, NaN). The class is written into the condition register. The operation that produced the word plays no part in this. A compare that came out unordered is reported with a separate flag, and it loads the NaN encoding.

A branch unit sends a 5-bit predicate selector with an evaluate strobe. The low four bits choose one of sixteen relations built from equal, greater, less and unordered. Bit 4 marks the signalling variant of that relation. One cycle later the block presents a registered predicate result. It also raises a one-cycle exception flag when a signalling predicate was evaluated while the stored code said unordered. The trap mechanism itself, rounding, arithmetic and the branch target logic belong to other blocks.

Top module: `fpcc_unit`

## Requirements
- R1: The condition code is presented on `cc_o` as N on bit 3, Z on bit 2, I on bit 1 and NAN on bit 0. After `res_upd`, a finite nonzero result (normalized or denormalized) loads 0000 when positive and 1000 when negative.
- R2: A zero result (exponent and fraction all zero) loads 0100 for +0 and 1100 for -0.
- R3: An infinite result (exponent all ones, fraction zero) loads 0010 for +inf and 1010 for -inf.
- R4: A NaN result (exponent all ones, fraction nonzero) loads 0001 or 1001, with N equal to the word's sign bit. Z and I are never set together with NAN, nor with each other.
- R5: When `cmp_unord` is high in the same cycle as `res_upd`, the NaN encoding is loaded (N = sign of `res_word`, NAN = 1), whatever the word holds. `cmp_unord` without `res_upd` has no effect.
- R6: In a cycle with `res_upd` low, `cc_o` holds its value, whatever `res_word` and `cmp_unord` do.
- R7: With eq = Z&!NAN, gt = !(NAN|Z|N), lt = N&!(NAN|Z) and un = NAN, the selector codes 0 to 7 (low four bits) give: 0 false, 1 eq, 2 gt, 3 gt|eq, 4 lt, 5 lt|eq, 6 gt|lt, 7 !un. `pred_true_o` shows the result in the cycle after `pred_eval`.
- R8: Code 15-k gives the complement of code k. So 8 is un, 9 un|eq, 10 un|gt, 11 un|gt|eq, 12 un|lt, 13 un|lt|eq, 14 !eq and 15 true. Selector bit 4 does not change the predicate value.
- R9: `sig_exc_o` is high for exactly the one cycle after a `pred_eval` whose selector has bit 4 set while the stored NAN bit is 1, and low in every other cycle.
- R10: `pred_true_o` holds its last value in cycles without `pred_eval`. A predicate evaluated in the same cycle as a result update sees the code from before that update.
- R11: Synchronous reset `rst` clears `cc_o`, `pred_true_o` and `sig_exc_o` to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_word | input | 32 | Single-precision result to classify |
| res_upd | input | 1 | Load the condition code from `res_word` |
| cmp_unord | input | 1 | The compare producing this update was unordered |
| pred_sel | input | 5 | Predicate selector: bit 4 signalling, bits 3:0 relation |
| pred_eval | input | 1 | Evaluate the selected predicate |
| cc_o | output | 4 | Stored condition code {N, Z, I, NAN} |
| pred_true_o | output | 1 | Registered predicate result |
| sig_exc_o | output | 1 | Registered signalling-predicate exception pulse |

## Verification
The classifier is driven with the sign-mirrored pairs of every data class: normal, smallest denormal, zero, infinity, quiet NaN and all-ones NaN. This separates sign handling from the exponent and fraction tests, and separates fraction-zero from fraction-nonzero at the all-ones exponent. Every one of those codes is then tested against all 32 selectors. This separates each relation from its complement and the quiet variants from the signalling ones, on ordered and unordered codes alike. Directed sequences check the unordered-compare override, the strobe gating of both registers, the single-cycle exception pulse and reset.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

   localparam int SEL_W = 5;

   typedef struct packed {
      logic n;
      logic z;
      logic i;
      logic nan;
   } fpcc_t;

   localparam fpcc_t CC_CLEAR = '{n: 1'b0, z: 1'b0, i: 1'b0, nan: 1'b0};

endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify
   import fpcc_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] word,
   input  logic                 force_unord,
   output fpcc_t                cc
);
   localparam int WORD_W = EXP_W + MAN_W + 1;

   logic             sgn;
   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] frac;
   logic             exp_max, exp_min, frac_zero;

   assign sgn       = word[WORD_W-1];
   assign expo      = word[WORD_W-2 -: EXP_W];
   assign frac      = word[MAN_W-1:0];
   assign exp_max   = &expo;
   assign exp_min   = ~|expo;
   assign frac_zero = ~|frac;

   always_comb begin
      cc   = CC_CLEAR;
      cc.n = sgn;
      if (force_unord || (exp_max && !frac_zero)) begin
         cc.nan = 1'b1;
      end else if (exp_max) begin
         cc.i = 1'b1;
      end else if (exp_min && frac_zero) begin
         cc.z = 1'b1;
      end
   end
endmodule

// File: rtl/fpcc_predicate.sv
module fpcc_predicate
   import fpcc_pkg::*;
#(
   parameter int PRED_IMPL = 0
) (
   input  fpcc_t            cc,
   input  logic [SEL_W-1:0] sel,
   output logic             hit
);
   logic eq_t, gt_t, lt_t, un_t;

   assign un_t = cc.nan;
   assign eq_t = cc.z & ~cc.nan;
   assign gt_t = ~(cc.nan | cc.z | cc.n);
   assign lt_t = cc.n & ~(cc.nan | cc.z);

   generate
      if (PRED_IMPL == 0) begin : g_mask
         logic [2:0] msk;
         logic       base;
         assign msk  = sel[3] ? ~sel[2:0] : sel[2:0];
         assign base = (msk[0] & eq_t) | (msk[1] & gt_t) | (msk[2] & lt_t);
         assign hit  = sel[3] ? ~base : base;
      end else begin : g_table
         always_comb begin
            case (sel[3:0])
               4'd0:    hit = 1'b0;
               4'd1:    hit = eq_t;
               4'd2:    hit = gt_t;
               4'd3:    hit = gt_t | eq_t;
               4'd4:    hit = lt_t;
               4'd5:    hit = lt_t | eq_t;
               4'd6:    hit = gt_t | lt_t;
               4'd7:    hit = ~un_t;
               4'd8:    hit = un_t;
               4'd9:    hit = un_t | eq_t;
               4'd10:   hit = un_t | gt_t;
               4'd11:   hit = un_t | gt_t | eq_t;
               4'd12:   hit = un_t | lt_t;
               4'd13:   hit = un_t | lt_t | eq_t;
               4'd14:   hit = ~eq_t;
               default: hit = 1'b1;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
   import fpcc_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter int PRED_IMPL = 0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [EXP_W+MAN_W:0]     res_word,
   input  logic                     res_upd,
   input  logic                     cmp_unord,
   input  logic [fpcc_pkg::SEL_W-1:0] pred_sel,
   input  logic                     pred_eval,
   output logic [3:0]               cc_o,
   output logic                     pred_true_o,
   output logic                     sig_exc_o
);
   generate
      if (EXP_W < 2)                       begin : g_bad_exp  $error("EXP_W must be at least 2");  end
      if (MAN_W < 1)                       begin : g_bad_man  $error("MAN_W must be at least 1");  end
      if (PRED_IMPL != 0 && PRED_IMPL != 1) begin : g_bad_impl $error("PRED_IMPL must be 0 or 1"); end
   endgenerate

   fpcc_t cc_q, cc_next;
   logic  hit;
   logic  pt_q, exc_q;

   fpcc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
      .word        (res_word),
      .force_unord (cmp_unord),
      .cc          (cc_next)
   );

   fpcc_predicate #(.PRED_IMPL(PRED_IMPL)) u_pred (
      .cc  (cc_q),
      .sel (pred_sel),
      .hit (hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cc_q  <= CC_CLEAR;
         pt_q  <= 1'b0;
         exc_q <= 1'b0;
      end else begin
         if (res_upd)   cc_q <= cc_next;
         if (pred_eval) pt_q <= hit;
         exc_q <= pred_eval & pred_sel[SEL_W-1] & cc_q.nan;
      end
   end

   assign cc_o        = cc_q;
   assign pred_true_o = pt_q;
   assign sig_exc_o   = exc_q;
endmodule

// File: rtl/fpcc_unit_chk.sv
module fpcc_unit_chk (
   input logic       clk,
   input logic       rst,
   input logic       res_upd,
   input logic       cmp_unord,
   input logic [4:0] pred_sel,
   input logic       pred_eval,
   input logic [3:0] cc_o,
   input logic       pred_true_o,
   input logic       sig_exc_o
);
   AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cc_o[2:0])); // R4
   AST_UNORD_LOAD: assert property (@(posedge clk) disable iff (rst)
      res_upd && cmp_unord |=> cc_o[0]); // R5
   AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !res_upd |=> $stable(cc_o)); // R6
   AST_FALSE_CODE: assert property (@(posedge clk) disable iff (rst)
      pred_eval && pred_sel[3:0] == 4'd0 |=> !pred_true_o); // R7
   AST_TRUE_CODE: assert property (@(posedge clk) disable iff (rst)
      pred_eval && pred_sel[3:0] == 4'd15 |=> pred_true_o); // R8
   AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (rst)
      sig_exc_o |-> $past(pred_eval && pred_sel[4] && cc_o[0])); // R9
   AST_EXC_RAISE: assert property (@(posedge clk) disable iff (rst)
      pred_eval && pred_sel[4] && cc_o[0] |=> sig_exc_o); // R9
   AST_PRED_HOLD: assert property (@(posedge clk) disable iff (rst)
      !pred_eval |=> $stable(pred_true_o)); // R10
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> cc_o == 4'd0 && !pred_true_o && !sig_exc_o); // R11
endmodule

bind fpcc_unit fpcc_unit_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .res_upd     (res_upd),
   .cmp_unord   (cmp_unord),
   .pred_sel    (pred_sel),
   .pred_eval   (pred_eval),
   .cc_o        (cc_o),
   .pred_true_o (pred_true_o),
   .sig_exc_o   (sig_exc_o)
);

// File: tb/tb_fpcc_unit.sv
`timescale 1ns/100ps
module tb_fpcc_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] res_word = '0;
   logic        res_upd = 1'b0;
   logic        cmp_unord = 1'b0;
   logic [4:0]  pred_sel = '0;
   logic        pred_eval = 1'b0;
   logic [3:0]  cc_o;
   logic        pred_true_o;
   logic        sig_exc_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   fpcc_unit dut (
      .clk(clk), .rst(rst), .res_word(res_word), .res_upd(res_upd),
      .cmp_unord(cmp_unord), .pred_sel(pred_sel), .pred_eval(pred_eval),
      .cc_o(cc_o), .pred_true_o(pred_true_o), .sig_exc_o(sig_exc_o)
   );

   // {word, expected code N Z I NAN}
   localparam logic [35:0] VEC [10] = '{
      {32'h3F80_0000, 4'b0000}, {32'hBF80_0000, 4'b1000},
      {32'h0000_0001, 4'b0000}, {32'h8000_0001, 4'b1000},
      {32'h0000_0000, 4'b0100}, {32'h8000_0000, 4'b1100},
      {32'h7F80_0000, 4'b0010}, {32'hFF80_0000, 4'b1010},
      {32'h7FC0_0000, 4'b0001}, {32'hFFFF_FFFF, 4'b1001}
   };

   function automatic logic exp_pred(input logic [3:0] cc, input logic [3:0] rel);
      logic un, eq, lt, gt;
      un = cc[0];
      eq = !un && cc[2];
      lt = !un && !cc[2] && cc[3];
      gt = !un && !eq && !lt;
      case (rel)
         4'd0:  return 1'b0;
         4'd1:  return eq;
         4'd2:  return gt;
         4'd3:  return gt || eq;
         4'd4:  return lt;
         4'd5:  return lt || eq;
         4'd6:  return gt || lt;
         4'd7:  return gt || lt || eq;
         4'd8:  return un;
         4'd9:  return un || eq;
         4'd10: return un || gt;
         4'd11: return un || gt || eq;
         4'd12: return un || lt;
         4'd13: return un || lt || eq;
         4'd14: return un || gt || lt;
         default: return 1'b1;
      endcase
   endfunction

   function automatic string class_tag(input logic [3:0] cc);
      if (cc[0]) return "R4";
      if (cc[1]) return "R3";
      if (cc[2]) return "R2";
      return "R1";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [31:0] w, input logic unord);
      @(negedge clk);
      res_word = w; cmp_unord = unord; res_upd = 1'b1;
      @(negedge clk);
      res_upd = 1'b0; cmp_unord = 1'b0;
   endtask

   task automatic evaluate(input logic [4:0] s);
      @(negedge clk);
      pred_sel = s; pred_eval = 1'b1;
      @(negedge clk);
      pred_eval = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R11 reset state
      chk("R11 cc after reset", 32'(cc_o), 0);
      chk("R11 pred after reset", 32'(pred_true_o), 0);
      chk("R11 exc after reset", 32'(sig_exc_o), 0);

      // table walk: classification and all 32 selectors
      for (int v = 0; v < 10; v++) begin
         load(VEC[v][35:4], 1'b0);
         chk(class_tag(VEC[v][3:0]), 32'(cc_o), 32'(VEC[v][3:0]));
         for (int s = 0; s < 32; s++) begin
            evaluate(5'(s));
            chk((s % 16) >= 8 ? "R8 predicate" : "R7 predicate",
                32'(pred_true_o), 32'(exp_pred(VEC[v][3:0], 4'(s))));
            chk("R9 exception", 32'(sig_exc_o), 32'((s >= 16) && VEC[v][0]));
         end
      end

      // R6: no strobe keeps the code
      load(32'hFF80_0000, 1'b0);
      @(negedge clk); res_word = 32'h7FC0_0000;
      @(negedge clk); res_word = 32'h0000_0000;
      @(negedge clk);
      chk("R6 hold without strobe", 32'(cc_o), 32'b1010);

      // R5: unordered compare overrides, ignored without strobe
      load(32'h3F80_0000, 1'b1);
      chk("R5 unordered +", 32'(cc_o), 32'b0001);
      load(32'hC000_0000, 1'b1);
      chk("R5 unordered -", 32'(cc_o), 32'b1001);
      load(32'h0000_0000, 1'b0);
      @(negedge clk); cmp_unord = 1'b1; res_word = 32'h7FC0_0000;
      @(negedge clk); cmp_unord = 1'b0;
      chk("R5 unord without strobe ignored", 32'(cc_o), 32'b0100);

      // R9 pulse length and R10 hold
      load(32'h7FC0_0001, 1'b0);
      evaluate(5'h18);
      chk("R9 exc raised", 32'(sig_exc_o), 1);
      chk("R8 signalling un", 32'(pred_true_o), 1);
      @(negedge clk);
      chk("R9 exc one cycle", 32'(sig_exc_o), 0);
      pred_sel = 5'h00;
      repeat (3) @(negedge clk);
      chk("R10 pred holds", 32'(pred_true_o), 1);

      // R10 same-cycle update sees the old code (NaN stored, eval GLE)
      @(negedge clk);
      res_word = 32'h3F80_0000; res_upd = 1'b1; pred_sel = 5'h07; pred_eval = 1'b1;
      @(negedge clk);
      res_upd = 1'b0; pred_eval = 1'b0;
      chk("R10 old code used", 32'(pred_true_o), 0);
      chk("R1 update landed", 32'(cc_o), 32'b0000);

      // R11 reset mid run
      load(32'hFFC0_0000, 1'b0);
      evaluate(5'h1F);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R11 cc cleared", 32'(cc_o), 0);
      chk("R11 pred cleared", 32'(pred_true_o), 0);
      chk("R11 exc cleared", 32'(sig_exc_o), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule